// File: doc/BRIEF.md
# Counting Semaphore Unit

This block holds one counting semaphore shared by a set of requester ports. Each port raises a request that is either an acquire or a release. The unit accepts exactly one operation per cycle, so every change to the count is atomic with respect to all ports. An acquire that finds a free slot is granted at once and takes one unit from the count. An acquire that finds the count at zero is parked in an in-order waiting list, and the port keeps its request raised until it is granted.

A release returns a unit. If somebody is waiting, the unit goes straight to the oldest waiter. In that case the count does not move and both the releaser and the waiter are acknowledged in the same cycle. If nobody is waiting, the count rises by one. The initial count, loaded at reset, is the largest number of ports that can hold the semaphore at once. A release that would push the count past that value is flagged as an error and changes nothing.

Each port works as a valid/ready pair. `req` is valid, and `ack` is ready, driven combinationally in the same cycle. An operation completes on a clock edge where both are high. Back-pressure rules:
- A port may hold `req` low for as long as it likes.
- Once `req` is raised, the port keeps it high and keeps `rel` stable until `ack` is seen.
- A parked acquire keeps `req` high through any number of cycles without `ack`.
- After `ack` the port may drop `req`, or keep it high to present a new operation.

Top module: `sem_unit`

## Requirements
- R1: After reset, `count` equals INIT_COUNT (2 by default), `ack` is all zero, `err` is low and no port is waiting.
- R2: An acquire (`rel`=0) chosen while `count` > 0 raises that port's `ack` bit in the same cycle, and `count` is one lower after the clock edge.
- R3: An acquire chosen while `count` is 0 is not acknowledged. The port joins the waiting list and `count` stays 0, never below zero.
- R4: A release (`rel`=1) chosen while no port waits and `count` < INIT_COUNT raises the releaser's `ack`, and `count` is one higher after the edge.
- R5: A release chosen while ports wait raises the releaser's `ack` and the `ack` of the oldest waiter in the same cycle, and leaves `count` unchanged. Waiters are served first-in first-out.
- R6: At most one new operation is accepted per cycle. The choice is round-robin: the search starts at the port just after the last accepted one, and port 0 has first priority after reset.
- R7: A waiting port is not offered to arbitration again. It receives no `ack` until a release hands it the unit, and that `ack` is a single-cycle pulse.
- R8: A release chosen while `count` equals INIT_COUNT and nobody waits is acknowledged, pulses `err` high for that one cycle, and leaves `count` unchanged.
- R9: `count` always stays within 0 to INIT_COUNT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_PORTS | Per-port request valid |
| rel | input | N_PORTS | Per-port operation: 1 release, 0 acquire |
| ack | output | N_PORTS | Per-port completion, same cycle as acceptance |
| err | output | 1 | Release beyond the initial count, one-cycle pulse |
| count | output | $clog2(INIT_COUNT+1) | Current semaphore value |

## Verification
`ack` and `err` are combinational, so they are due in the same cycle as the request that causes them. `count` changes on the next rising edge. The bench applies stimulus just after a falling edge and samples `ack` and `err` one time unit later, before the rising edge. It then waits for the next falling edge to check `count`, after exactly one register stage. For a parked acquire, the bench keeps the request high for several cycles and checks each cycle that no `ack` appears, until a release hands it the unit. At that point the waiter's `ack` is due in the same cycle as the releaser's.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic {
    OP_TAKE = 1'b0,
    OP_GIVE = 1'b1
  } sem_op_e;

  function automatic int wrap_next(input int idx, input int n);
    return (idx == n - 1) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/sem_rr_arb.sv
module sem_rr_arb #(
  parameter int N_PORTS = 4,
  localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PORTS-1:0] cand,
  output logic               win_any,
  output logic [IDX_W-1:0]   win_idx,
  output logic [N_PORTS-1:0] win_oh
);
  import sem_pkg::*;

  logic [IDX_W-1:0] start_q;

  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    win_oh  = '0;
    for (int k = 0; k < N_PORTS; k++) begin
      int j;
      j = int'(start_q) + k;
      if (j >= N_PORTS) j = j - N_PORTS;
      if (!win_any && cand[j]) begin
        win_any   = 1'b1;
        win_idx   = IDX_W'(j);
        win_oh[j] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= '0;
    else if (win_any) start_q <= IDX_W'(wrap_next(int'(win_idx), N_PORTS));
  end

  // R6: a single winner, and only among candidates
  a_r6_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh) && ((win_oh & ~cand) == '0));
  a_r6_any_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cand != '0) |-> win_any);
endmodule

// File: rtl/sem_waitq.sv
module sem_waitq #(
  parameter int N_PORTS = 4,
  localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int OCC_W = $clog2(N_PORTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] push_id,
  input  logic             pop,
  output logic [IDX_W-1:0] head_id,
  output logic             empty,
  output logic             full
);
  import sem_pkg::*;

  logic [IDX_W-1:0] slot_q [N_PORTS];
  logic [IDX_W-1:0] wr_q, rd_q;
  logic [OCC_W-1:0] occ_q;

  assign empty   = (occ_q == '0);
  assign full    = (occ_q == OCC_W'(N_PORTS));
  assign head_id = slot_q[rd_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
      for (int i = 0; i < N_PORTS; i++) slot_q[i] <= '0;
    end else begin
      if (push) begin
        slot_q[wr_q] <= push_id;
        wr_q <= IDX_W'(wrap_next(int'(wr_q), N_PORTS));
      end
      if (pop) rd_q <= IDX_W'(wrap_next(int'(rd_q), N_PORTS));
      if (push && !pop) occ_q <= occ_q + 1'b1;
      else if (pop && !push) occ_q <= occ_q - 1'b1;
    end
  end

  // R3: a parked port always finds room
  a_r3_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R5: a hand-off only happens with someone waiting
  a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/sem_unit.sv
module sem_unit #(
  parameter int N_PORTS    = 4,
  parameter int INIT_COUNT = 2,
  localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int CNT_W = $clog2(INIT_COUNT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PORTS-1:0] req,
  input  logic [N_PORTS-1:0] rel,
  output logic [N_PORTS-1:0] ack,
  output logic               err,
  output logic [CNT_W-1:0]   count
);
  import sem_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(INIT_COUNT);

  logic [CNT_W-1:0]   count_q, count_d;
  logic [N_PORTS-1:0] parked_q, parked_d;
  logic [N_PORTS-1:0] cand, win_oh, ack_d;
  logic               win_any, err_d;
  logic [IDX_W-1:0]   win_idx, head_id;
  logic               q_push, q_pop, q_empty, q_full;
  sem_op_e            op;

  assign cand = req & ~parked_q;
  assign op   = sem_op_e'(rel[win_idx]);

  sem_rr_arb #(.N_PORTS(N_PORTS)) u_arb (
    .clk(clk), .rst_n(rst_n), .cand(cand),
    .win_any(win_any), .win_idx(win_idx), .win_oh(win_oh)
  );

  sem_waitq #(.N_PORTS(N_PORTS)) u_wq (
    .clk(clk), .rst_n(rst_n), .push(q_push), .push_id(win_idx),
    .pop(q_pop), .head_id(head_id), .empty(q_empty), .full(q_full)
  );

  always_comb begin
    count_d  = count_q;
    parked_d = parked_q;
    ack_d    = '0;
    err_d    = 1'b0;
    q_push   = 1'b0;
    q_pop    = 1'b0;
    if (win_any) begin
      if (op == OP_GIVE) begin
        ack_d = win_oh;
        if (!q_empty) begin
          q_pop = 1'b1;
          ack_d[head_id]    = 1'b1;
          parked_d[head_id] = 1'b0;
        end else if (count_q == CNT_MAX) begin
          err_d = 1'b1;
        end else begin
          count_d = count_q + 1'b1;
        end
      end else begin
        if (count_q != '0) begin
          ack_d   = win_oh;
          count_d = count_q - 1'b1;
        end else begin
          q_push            = 1'b1;
          parked_d[win_idx] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= CNT_MAX;
      parked_q <= '0;
    end else begin
      count_q  <= count_d;
      parked_q <= parked_d;
    end
  end

  assign ack   = ack_d;
  assign err   = err_d;
  assign count = count_q;

  // R9: value stays in range
  a_r9_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_MAX);
  // R6: one operation per cycle moves the count by at most one
  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1)
             || ($past(count_q) == count_q + 1'b1));
  // R8: an over-release is flagged only at the cap and leaves the count alone
  a_r8_err_at_cap: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (count_q == CNT_MAX) && q_empty);
  a_r8_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> $stable(count_q));
  // R7: acks go only to requesting ports; a parked port is freed by its ack
  a_r7_ack_to_req: assert property (@(posedge clk) disable iff (!rst_n)
    (ack & ~req) == '0);
  // R3: nothing is parked while units are free
  a_r3_park_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |-> (count_q == '0));

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    // R7: a parked port holds its request until handed the unit
    a_r7_parked_holds: assert property (@(posedge clk) disable iff (!rst_n)
      parked_q[g] |-> req[g]);
    a_r7_park_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (parked_q[g] && ack[g]) |=> !parked_q[g]);
  end
endmodule

// File: tb/sim_sem_unit.sv
module sim_sem_unit;
  localparam int CLK_P = 10;
  localparam int NP    = 4;
  localparam int INIT  = 2;
  localparam int CW    = $clog2(INIT + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] req = '0;
  logic [NP-1:0] rel = '0;
  logic [NP-1:0] ack;
  logic          err;
  logic [CW-1:0] count;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  sem_unit #(.N_PORTS(NP), .INIT_COUNT(INIT)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .rel(rel),
    .ack(ack), .err(err), .count(count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // apply inputs after a falling edge, check combinational outputs
  task automatic drive(input logic [NP-1:0] r, input logic [NP-1:0] op,
                       input string tag, input int exp_ack, input int exp_err);
    req = r;
    rel = op;
    #1;
    chk({tag, " ack"}, int'(ack), exp_ack);
    chk({tag, " err"}, int'(err), exp_err);
  endtask

  // after the rising edge, check the registered count
  task automatic settle(input string tag, input int exp_cnt);
    @(negedge clk);
    chk({tag, " count"}, int'(count), exp_cnt);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 count", int'(count), INIT);
    chk("R1 ack", int'(ack), 0);
    chk("R1 err", int'(err), 0);
  endtask

  task automatic t_take();
    drive(4'b0001, 4'b0000, "R2 take p0", 4'b0001, 0);
    settle("R2 take p0", 1);
  endtask

  task automatic t_contend_and_park();
    // round-robin now starts at port 1
    drive(4'b0110, 4'b0000, "R6 p1 over p2", 4'b0010, 0);
    settle("R2 take p1", 0);
    drive(4'b0100, 4'b0000, "R3 p2 parks", 4'b0000, 0);
    settle("R3 zero floor", 0);
    drive(4'b1100, 4'b0000, "R7 p2 parked, p3 parks", 4'b0000, 0);
    settle("R3 zero floor p3", 0);
    drive(4'b1100, 4'b0000, "R7 no re-grant", 4'b0000, 0);
    settle("R7 idle wait", 0);
  endtask

  task automatic t_handoff();
    drive(4'b1101, 4'b0001, "R5 p0 gives to p2", 4'b0101, 0);
    settle("R5 count held", 0);
    drive(4'b1010, 4'b0010, "R5 p1 gives to p3 fifo", 4'b1010, 0);
    settle("R5 count held 2", 0);
    drive(4'b0000, 4'b0000, "R7 ack single pulse", 4'b0000, 0);
    @(negedge clk);
    drive(4'b0100, 4'b0100, "R4 p2 gives", 4'b0100, 0);
    settle("R4 inc", 1);
    drive(4'b1000, 4'b1000, "R4 p3 gives", 4'b1000, 0);
    settle("R4 inc to cap", 2);
  endtask

  task automatic t_over_release();
    drive(4'b0010, 4'b0010, "R8 over-release", 4'b0010, 1);
    settle("R8 count kept", 2);
    drive(4'b0000, 4'b0000, "R8 err one cycle", 4'b0000, 0);
    chk("R9 cap", int'(count), INIT);
    @(negedge clk);
  endtask

  task automatic t_round_robin();
    // last accepted was port 1, so search starts at port 2
    drive(4'b1011, 4'b0000, "R6 p3 first", 4'b1000, 0);
    settle("R6 after p3", 1);
    drive(4'b0011, 4'b0000, "R6 wrap to p0", 4'b0001, 0);
    settle("R6 after p0", 0);
    drive(4'b0010, 4'b0000, "R3 p1 parks", 4'b0000, 0);
    settle("R3 floor again", 0);
    drive(4'b1010, 4'b1000, "R5 p3 gives to p1", 4'b1010, 0);
    settle("R5 held", 0);
    drive(4'b0011, 4'b0011, "R6 serial give p0", 4'b0001, 0);
    settle("R4 give p0", 1);
    drive(4'b0010, 4'b0010, "R6 serial give p1", 4'b0010, 0);
    settle("R4 give p1", 2);
    drive(4'b0000, 4'b0000, "R1 idle", 4'b0000, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_take();
    t_contend_and_park();
    t_handoff();
    t_over_release();
    t_round_robin();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule